// File: doc/BRIEF.md
# Receive Character Filter with Xon/Xoff and Special-Character Detection

This block sits between a UART receiver and its receive FIFO. Each time the receiver presents a finished character, the block compares it against four programmed compare values. These are two Xon/Xoff pairs, called set 1 and set 2. The block decides in the same cycle whether the character is written into the FIFO. It also keeps sticky interrupt flags for Xoff, Xon and special-character events, and it tells the transmitter whether it must pause.

A 2-bit compare mode selects which Xon/Xoff pair is active, or turns comparison off. A separate enable turns on special-character detection. Special-character detection compares every character against the set-2 Xoff value. When set 2 is active, a received set-2 Xoff is consumed as flow control: it is not stored, and it raises both the Xoff and the special-character flags. Otherwise a special-character match is stored normally and flagged.

Top module: `rx_char_filter`

## Requirements
- R1: After reset, all three interrupt flags, `tx_halt_o` and `fifo_wr_o` are 0.
- R2: `fifo_wr_o` is asserted only in a cycle where `rx_valid_i` is high, at most once per character, and `fifo_data_o` equals `rx_data_i` in that cycle.
- R3: With `spec_en_i` low, a character equal to the set-2 Xoff value sets no special flag and, in mode 2'b00, is written to the FIFO.
- R4: With `spec_en_i` high and mode 2'b00 or 2'b10, a character equal to the set-2 Xoff value in all 8 bits (bit 0 is the character LSB) is written to the FIFO, and `irq_spec_o` is 1 from the next cycle. A character differing in any bit does not set the flag.
- R5: In mode 2'b01 (set 2 active), a received set-2 Xoff is not written. `irq_xoff_o` is 1 from the next cycle, and with `spec_en_i` high `irq_spec_o` is also 1 from the next cycle.
- R6: In mode 2'b10 (set 1 active), a received active Xoff is not written, sets `irq_xoff_o` and sets `tx_halt_o` from the next cycle. A received active Xon is not written, sets `irq_xon_o` and clears `tx_halt_o` from the next cycle.
- R7: Xon/Xoff values of the inactive set are written to the FIFO and leave `tx_halt_o` unchanged.
- R8: In modes 2'b00 and 2'b11 no Xon/Xoff comparison is made, every character is written, and `tx_halt_o` is 0 from the cycle after such a mode is applied.
- R9: The interrupt flags stay set until `irq_clr_i` is sampled high. A set event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received character strobe, one cycle per character |
| rx_data_i | input | 8 | Received character |
| xon1_i | input | 8 | Set-1 Xon compare value |
| xoff1_i | input | 8 | Set-1 Xoff compare value |
| xon2_i | input | 8 | Set-2 Xon compare value |
| xoff2_i | input | 8 | Set-2 Xoff compare value, also the special character |
| spec_en_i | input | 1 | Special-character detection enable |
| fc_mode_i | input | 2 | 00/11 no compare, 01 set 2 active, 10 set 1 active |
| irq_clr_i | input | 1 | Clears all interrupt flags (status read) |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | Character to write |
| irq_spec_o | output | 1 | Sticky special-character flag |
| irq_xoff_o | output | 1 | Sticky Xoff-received flag |
| irq_xon_o | output | 1 | Sticky Xon-received flag |
| tx_halt_o | output | 1 | Transmitter must pause |

## Verification
The FIFO write decision is combinational, so it is sampled in the strobe cycle before the rising edge. The interrupt flags and `tx_halt_o` pass through one register each, so they are sampled just after the edge that takes the strobe. Each task drives its inputs on the falling edge and reads results at these two points, so no check depends on process ordering at the clock edge.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  typedef enum logic [1:0] {
    FC_OFF  = 2'b00,
    FC_SET2 = 2'b01,
    FC_SET1 = 2'b10,
    FC_OFF3 = 2'b11
  } fc_mode_e;

  typedef struct packed {
    logic xon;
    logic xoff;
    logic spec;
  } evt_t;

  localparam int unsigned NUM_IRQ = 3;
endpackage

// File: rtl/rx_char_match.sv
module rx_char_match
  import rx_filt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] xon1_i,
  input  logic [DW-1:0] xoff1_i,
  input  logic [DW-1:0] xon2_i,
  input  logic [DW-1:0] xoff2_i,
  input  logic          spec_en_i,
  input  fc_mode_e      mode_i,
  output logic          active_o,
  output logic          wr_o,
  output evt_t          evt_o
);
  logic [DW-1:0] act_xon, act_xoff;
  logic          hit_xoff, hit_xon;

  always_comb begin
    active_o = (mode_i == FC_SET1) || (mode_i == FC_SET2);
    act_xon  = (mode_i == FC_SET1) ? xon1_i  : xon2_i;
    act_xoff = (mode_i == FC_SET1) ? xoff1_i : xoff2_i;
    hit_xoff = valid_i && active_o && (data_i == act_xoff);
    // xoff takes precedence if both compare values are equal
    hit_xon  = valid_i && active_o && (data_i == act_xon) && !hit_xoff;
    evt_o.xoff = hit_xoff;
    evt_o.xon  = hit_xon;
    evt_o.spec = valid_i && spec_en_i && (data_i == xoff2_i);
    wr_o       = valid_i && !hit_xoff && !hit_xon;
  end
endmodule

// File: rtl/rx_irq_flags.sv
module rx_irq_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i)    flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_flow_state.sv
module rx_flow_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic xoff_i,
  input  logic xon_i,
  output logic halt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        halt_o <= 1'b0;
    else if (!active_i) halt_o <= 1'b0;
    else if (xoff_i)    halt_o <= 1'b1;
    else if (xon_i)     halt_o <= 1'b0;
  end
endmodule

// File: rtl/rx_char_filter.sv
module rx_char_filter
  import rx_filt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic [DW-1:0] xon1_i,
  input  logic [DW-1:0] xoff1_i,
  input  logic [DW-1:0] xon2_i,
  input  logic [DW-1:0] xoff2_i,
  input  logic          spec_en_i,
  input  logic [1:0]    fc_mode_i,
  input  logic          irq_clr_i,
  output logic          fifo_wr_o,
  output logic [DW-1:0] fifo_data_o,
  output logic          irq_spec_o,
  output logic          irq_xoff_o,
  output logic          irq_xon_o,
  output logic          tx_halt_o
);
  evt_t               evt;
  logic               active;
  logic [NUM_IRQ-1:0] flags;

  rx_char_match #(.DW(DW)) i_match (
    .valid_i  (rx_valid_i),
    .data_i   (rx_data_i),
    .xon1_i   (xon1_i),
    .xoff1_i  (xoff1_i),
    .xon2_i   (xon2_i),
    .xoff2_i  (xoff2_i),
    .spec_en_i(spec_en_i),
    .mode_i   (fc_mode_e'(fc_mode_i)),
    .active_o (active),
    .wr_o     (fifo_wr_o),
    .evt_o    (evt)
  );

  assign fifo_data_o = rx_data_i;

  rx_irq_flags #(.N(NUM_IRQ)) i_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt),
    .clr_i (irq_clr_i),
    .flag_o(flags)
  );

  assign irq_spec_o = flags[0];
  assign irq_xoff_o = flags[1];
  assign irq_xon_o  = flags[2];

  rx_flow_state i_flow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .xoff_i  (evt.xoff),
    .xon_i   (evt.xon),
    .halt_o  (tx_halt_o)
  );

  p_wr_needs_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> rx_valid_i);

  p_spec_stored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && spec_en_i && rx_data_i == xoff2_i && fc_mode_i == 2'b00)
    |-> fifo_wr_o);

  p_spec_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && spec_en_i && rx_data_i == xoff2_i) |=> irq_spec_o);

  p_xoff2_swallow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fc_mode_i == 2'b01 && rx_data_i == xoff2_i) |-> !fifo_wr_o);

  p_xoff2_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && spec_en_i && fc_mode_i == 2'b01 && rx_data_i == xoff2_i)
    |=> (irq_xoff_o && irq_spec_o));

  p_halt_on_xoff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fc_mode_i == 2'b10 && rx_data_i == xoff1_i) |=> tx_halt_o);

  p_off_no_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_mode_i == 2'b00 || fc_mode_i == 2'b11) |=> !tx_halt_o);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_spec_o && !irq_clr_i) |=> irq_spec_o);
endmodule

// File: tb/test_rx_char_filter.sv
module test_rx_char_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] XON1 = 8'h11, XOFF1 = 8'h13, XON2 = 8'h91, XOFF2 = 8'h93;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       spec_en = 1'b0;
  logic [1:0] fc_mode = 2'b00;
  logic       irq_clr = 1'b0;
  logic       fifo_wr, irq_spec, irq_xoff, irq_xon, tx_halt;
  logic [7:0] fifo_data;
  int checks = 0, fails = 0;
  logic s_wr;
  logic [7:0] s_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_char_filter i_rx_char_filter (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .xon1_i(XON1), .xoff1_i(XOFF1), .xon2_i(XON2), .xoff2_i(XOFF2),
    .spec_en_i(spec_en), .fc_mode_i(fc_mode), .irq_clr_i(irq_clr),
    .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data), .irq_spec_o(irq_spec),
    .irq_xoff_o(irq_xoff), .irq_xon_o(irq_xon), .tx_halt_o(tx_halt)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample write before rising edge, registers after it
  task automatic send(logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = d;
    #2;
    s_wr   = fifo_wr;
    s_data = fifo_data;
    @(posedge clk);
    #2;
    rx_valid = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 spec", irq_spec, 0); check("R1 xoff", irq_xoff, 0);
    check("R1 xon", irq_xon, 0);   check("R1 halt", tx_halt, 0);
    check("R1 wr", fifo_wr, 0);
  endtask

  task automatic t_passthru();
    fc_mode = 2'b00; spec_en = 1'b0;
    send(8'h41);
    check("R2 wr", s_wr, 1); check("R2 data", s_data, 8'h41);
    @(negedge clk); #1; check("R2 idle wr", fifo_wr, 0);
    send(XOFF1);
    check("R8 stored", s_wr, 1); check("R8 halt", tx_halt, 0);
    fc_mode = 2'b11;
    send(XON2);
    check("R8 mode11 stored", s_wr, 1);
    check("R8 no xon flag", irq_xon, 0);
    fc_mode = 2'b00;
  endtask

  task automatic t_spec_off();
    spec_en = 1'b0;
    send(XOFF2);
    check("R3 stored", s_wr, 1); check("R3 no flag", irq_spec, 0);
  endtask

  task automatic t_spec_on();
    spec_en = 1'b1;
    send(XOFF2 ^ 8'h01);
    check("R4 lsb differs stored", s_wr, 1); check("R4 lsb no flag", irq_spec, 0);
    send(XOFF2);
    check("R4 stored", s_wr, 1); check("R4 flag", irq_spec, 1);
    clear_flags();
    check("R9 cleared", irq_spec, 0);
  endtask

  task automatic t_set1();
    fc_mode = 2'b10; spec_en = 1'b1;
    send(XOFF2);
    check("R4 set1 stored", s_wr, 1); check("R4 set1 flag", irq_spec, 1);
    check("R7 xoff2 no halt", tx_halt, 0);
    send(XOFF1);
    check("R6 xoff swallowed", s_wr, 0); check("R6 xoff flag", irq_xoff, 1);
    check("R6 halt", tx_halt, 1);
    send(XON2);
    check("R7 xon2 stored", s_wr, 1); check("R7 still halted", tx_halt, 1);
    send(XON1);
    check("R6 xon swallowed", s_wr, 0); check("R6 xon flag", irq_xon, 1);
    check("R6 resumed", tx_halt, 0);
    clear_flags();
  endtask

  task automatic t_set2();
    fc_mode = 2'b01; spec_en = 1'b1;
    send(XOFF2);
    check("R5 swallowed", s_wr, 0); check("R5 xoff flag", irq_xoff, 1);
    check("R5 spec flag", irq_spec, 1); check("R5 halt", tx_halt, 1);
    send(XOFF1);
    check("R7 xoff1 stored", s_wr, 1); check("R7 halt kept", tx_halt, 1);
    send(XON2);
    check("R6 set2 xon swallowed", s_wr, 0); check("R6 set2 resumed", tx_halt, 0);
    clear_flags();
    spec_en = 1'b0;
    send(XOFF2);
    check("R5 no spec when disabled", irq_spec, 0); check("R5 xoff only", irq_xoff, 1);
    clear_flags();
  endtask

  task automatic t_sticky();
    fc_mode = 2'b00; spec_en = 1'b1;
    send(XOFF2);
    repeat (3) @(negedge clk);
    check("R9 held", irq_spec, 1);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = XOFF2; irq_clr = 1'b1;
    @(posedge clk); #2;
    rx_valid = 1'b0; irq_clr = 1'b0;
    check("R9 set wins", irq_spec, 1);
    clear_flags();
    check("R9 clear", irq_spec, 0);
  endtask

  task automatic t_mode_off();
    fc_mode = 2'b10;
    send(XOFF1);
    check("R6 halt before off", tx_halt, 1);
    @(negedge clk); fc_mode = 2'b00;
    @(posedge clk); #2;
    check("R8 halt dropped", tx_halt, 0);
    clear_flags();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_spec_off();
    t_spec_on();
    t_set1();
    t_set2();
    t_sticky();
    t_mode_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule